// File: doc/BRIEF.md
# Dynamic Retention Test Sequencer

This block is a self-test engine for a refreshed memory. It finds cells whose stored charge leaks away between refreshes. Over a host-supplied address window it makes one full pass of writes with a solid pattern, every bit the same. It then stays off the memory for a programmable number of cycles while the memory controller keeps refreshing on its own. Finally it reads the whole window back. Each beat that comes back is compared with the pattern, and the number of flipped bits is added to a running total.

One repetition runs four such passes in a fixed order: ascending with zeros, ascending with ones, descending with zeros, then descending with ones. The flipped-bit counts of all four passes go into a single per-repetition result. The host gives the window, the idle time and the repetition count with a start pulse, and it collects one result for each repetition. Writes use a valid/ready handshake. Reads use a request channel and a separate response channel, with one read in flight at a time.

Top module: `drt_seq`

## Requirements
- R1: Within each pass, every write of the window completes before the idle phase begins. No write or read request is issued during the idle phase, and all reads of the window come after it.
- R2: The idle phase lasts exactly `cfg_wait` cycles, counted from the last write handshake to the first cycle with `rd_req_valid` high. A value of 0 is treated as 1.
- R3: Pass index p runs 0,1,2,3 in order. Bit 1 of p selects the direction (0 ascending from `cfg_base` to `cfg_last`, 1 descending from `cfg_last` to `cfg_base`). Bit 0 of p selects the pattern bit.
- R4: Every write beat carries all `DW` data bits equal to the pattern bit of the current pass. Address and data stay stable while `wr_valid` is waiting for `wr_ready`.
- R5: Read requests visit the window in the same order as the writes of that pass, one request per address. A response beat is counted only in a cycle where `rd_data_valid` and `rd_data_ready` are both high. Other beats have no effect on the result.
- R6: The result of a repetition is the sum, over all response beats of its four passes, of the number of ones in (read data XOR the pattern word).
- R7: The running total saturates at 2^`ERR_W`-1 and never wraps.
- R8: The run performs `cfg_reps` repetitions, and 0 is treated as 1. After each repetition `rep_errors` holds that repetition's result, `rep_valid` pulses for one cycle and `reps_done` increments. The total restarts from zero for the next repetition.
- R9: `busy` rises in the cycle after an accepted start. `done` pulses for exactly one cycle, in the first cycle in which `busy` is low again.
- R10: A start pulse while `busy` is high is ignored. The configuration is captured only when a start is accepted.
- R11: After reset, `busy`, `done`, `wr_valid`, `rd_req_valid`, `rd_data_ready`, `rep_valid`, `rep_errors` and `reps_done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted only when idle |
| cfg_base | input | AW | First address of the window |
| cfg_last | input | AW | Last address of the window (not below `cfg_base`) |
| cfg_wait | input | WAIT_W | Idle phase length in cycles |
| cfg_reps | input | REP_W | Number of repetitions |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data (solid pattern) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_data_valid | input | 1 | Read response valid |
| rd_data_ready | output | 1 | Sequencer can take a response |
| rd_data | input | DW | Read response data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| rep_valid | output | 1 | One-cycle pulse when `rep_errors` is updated |
| rep_errors | output | ERR_W | Flipped-bit count of the last finished repetition |
| reps_done | output | REP_W | Repetitions finished in this run |

## Verification
The bench's memory model carries stuck-at-0 and stuck-at-1 masks for each address. The error count expected for a window is therefore known in closed form: twice the population of the masks in that window. A clean memory checks that the count stays at zero and that the pass and address ordering is right. Sparse faults of both polarities check that each mask is seen only under its opposite pattern. Faults placed just outside the window check that the bounds are exclusive of them, and a single-address window checks the case where the first address is also the last. A memory whose bits all read as one drives the total into saturation. Garbage response beats sent while `rd_data_ready` is low, together with a second start pulse in the middle of a run, check that ignored stimulus leaves the result and the run length unchanged.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_HOLD,
    PH_RQ,
    PH_RSP,
    PH_TALLY
  } drt_phase_e;

  localparam int NUM_PASSES = 4;

  // bit 1 of the pass index: descending address order
  function automatic logic pass_is_down(input logic [1:0] p);
    return p[1];
  endfunction

  // bit 0 of the pass index: pattern bit
  function automatic logic pass_bit(input logic [1:0] p);
    return p[0];
  endfunction

endpackage

// File: rtl/drt_addr_gen.sv
module drt_addr_gen #(
  parameter int AW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          down,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  logic          down_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      addr_q <= down ? hi : lo;
      down_q <= down;
    end else if (step) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr   = addr_q;
  assign at_end = down_q ? (addr_q == lo) : (addr_q == hi);

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (load || step) |=> (addr_q >= lo && addr_q <= hi)); // R3

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q != $past(addr_q))); // R5

endmodule

// File: rtl/drt_hold_timer.sv
module drt_hold_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_tick;

  assign last_tick = (limit == '0) ? '0 : limit - 1'b1;
  assign expire    = run && (cnt_q == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_tick)); // R2

endmodule

// File: rtl/drt_err_accum.sv
module drt_err_accum #(
  parameter int DW = 256,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          beat,
  input  logic [DW-1:0] rdata,
  input  logic          expect_one,
  output logic [EW-1:0] total
);
  localparam int PW = $clog2(DW + 1);

  function automatic logic [PW-1:0] ones_in(input logic [DW-1:0] v);
    logic [PW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++) c = c + PW'(v[i]);
    return c;
  endfunction

  logic [PW-1:0] beat_errs;
  logic [EW:0]   sum;
  logic [EW-1:0] acc_q;

  assign beat_errs = ones_in(rdata ^ {DW{expect_one}});
  assign sum       = {1'b0, acc_q} + (EW+1)'(beat_errs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (beat)  acc_q <= sum[EW] ? '1 : sum[EW-1:0];
  end

  assign total = acc_q;

  AST_ACC_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (acc_q >= $past(acc_q))); // R6

  AST_SAT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '1 && !clear) |=> (acc_q == '1)); // R7

  AST_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !clear) |=> $stable(acc_q)); // R5

endmodule

// File: rtl/drt_seq.sv
module drt_seq
  import drt_pkg::*;
#(
  parameter int AW     = 28,
  parameter int DW     = 256,
  parameter int ERR_W  = 32,
  parameter int WAIT_W = 32,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW-1:0]     cfg_last,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [REP_W-1:0]  cfg_reps,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_data_valid,
  output logic              rd_data_ready,
  input  logic [DW-1:0]     rd_data,
  output logic              busy,
  output logic              done,
  output logic              rep_valid,
  output logic [ERR_W-1:0]  rep_errors,
  output logic [REP_W-1:0]  reps_done
);
  drt_phase_e phase_q, phase_d;
  logic [1:0]        pass_q, pass_d;
  logic [AW-1:0]     base_q, last_q;
  logic [WAIT_W-1:0] wait_q;
  logic [REP_W-1:0]  reps_q, rep_cnt_q;
  logic [ERR_W-1:0]  rep_errors_q;
  logic              rep_valid_q, done_q;

  // named internal events
  logic wr_fire, rq_fire, rsp_fire;
  logic take_start, tally, addr_load, addr_step, last_rep;
  logic hold_expire, at_end;
  logic [AW-1:0]    cur_addr, lo_sel, hi_sel;
  logic [ERR_W-1:0] acc_total;
  logic [REP_W:0]   reps_eff, rep_next;

  assign wr_fire  = wr_valid && wr_ready;
  assign rq_fire  = rd_req_valid && rd_req_ready;
  assign rsp_fire = rd_data_valid && rd_data_ready;

  assign reps_eff = (reps_q == '0) ? (REP_W+1)'(1) : {1'b0, reps_q};
  assign rep_next = {1'b0, rep_cnt_q} + 1'b1;
  assign last_rep = (rep_next >= reps_eff);

  assign lo_sel = (phase_q == PH_IDLE) ? cfg_base : base_q;
  assign hi_sel = (phase_q == PH_IDLE) ? cfg_last : last_q;

  always_comb begin
    phase_d    = phase_q;
    pass_d     = pass_q;
    take_start = 1'b0;
    tally      = 1'b0;
    addr_load  = 1'b0;
    addr_step  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        take_start = 1'b1;
        pass_d     = 2'd0;
        phase_d    = PH_FILL;
        addr_load  = 1'b1;
      end
      PH_FILL: if (wr_fire) begin
        if (at_end) phase_d = PH_HOLD;
        else        addr_step = 1'b1;
      end
      PH_HOLD: if (hold_expire) begin
        phase_d   = PH_RQ;
        addr_load = 1'b1;
      end
      PH_RQ: if (rq_fire) phase_d = PH_RSP;
      PH_RSP: if (rsp_fire) begin
        if (!at_end) begin
          addr_step = 1'b1;
          phase_d   = PH_RQ;
        end else if (pass_q == 2'(NUM_PASSES - 1)) begin
          phase_d = PH_TALLY;
        end else begin
          pass_d    = pass_q + 1'b1;
          phase_d   = PH_FILL;
          addr_load = 1'b1;
        end
      end
      PH_TALLY: begin
        tally = 1'b1;
        if (last_rep) phase_d = PH_IDLE;
        else begin
          pass_d    = 2'd0;
          phase_d   = PH_FILL;
          addr_load = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      pass_q       <= '0;
      base_q       <= '0;
      last_q       <= '0;
      wait_q       <= '0;
      reps_q       <= '0;
      rep_cnt_q    <= '0;
      rep_errors_q <= '0;
      rep_valid_q  <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      pass_q      <= pass_d;
      rep_valid_q <= tally;
      done_q      <= tally && last_rep;
      if (take_start) begin
        base_q       <= cfg_base;
        last_q       <= cfg_last;
        wait_q       <= cfg_wait;
        reps_q       <= cfg_reps;
        rep_cnt_q    <= '0;
        rep_errors_q <= '0;
      end else if (tally) begin
        rep_errors_q <= acc_total;
        rep_cnt_q    <= rep_cnt_q + 1'b1;
      end
    end
  end

  drt_addr_gen #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (addr_load),
    .step   (addr_step),
    .down   (pass_is_down(pass_d)),
    .lo     (lo_sel),
    .hi     (hi_sel),
    .addr   (cur_addr),
    .at_end (at_end)
  );

  drt_hold_timer #(.CW(WAIT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (phase_q == PH_HOLD),
    .limit  (wait_q),
    .expire (hold_expire)
  );

  drt_err_accum #(.DW(DW), .EW(ERR_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (take_start || tally),
    .beat       (rsp_fire),
    .rdata      (rd_data),
    .expect_one (pass_bit(pass_q)),
    .total      (acc_total)
  );

  assign wr_valid      = (phase_q == PH_FILL);
  assign wr_addr       = cur_addr;
  assign wr_data       = {DW{pass_bit(pass_q)}};
  assign rd_req_valid  = (phase_q == PH_RQ);
  assign rd_req_addr   = cur_addr;
  assign rd_data_ready = (phase_q == PH_RSP);
  assign busy          = (phase_q != PH_IDLE);
  assign done          = done_q;
  assign rep_valid     = rep_valid_q;
  assign rep_errors    = rep_errors_q;
  assign reps_done     = rep_cnt_q;

  AST_FILL_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && at_end) |=> (!wr_valid && !rd_req_valid)); // R1

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R4

  AST_RQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(base_q) && $stable(last_q) && $stable(reps_q))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_REPS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, rep_cnt_q} < reps_eff)); // R8

endmodule

// File: tb/sim_drt_seq.sv
module sim_drt_seq;
  localparam int AW = 4, DW = 256, EW = 12, WW = 32, RW = 8;
  localparam int SATV = (1 << EW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_last = '0;
  logic [WW-1:0] cfg_wait = '0;
  logic [RW-1:0] cfg_reps = '0;
  logic wr_valid, wr_ready = 1'b0, rd_req_valid, rd_req_ready = 1'b0;
  logic rd_data_valid = 1'b0, rd_data_ready;
  logic [AW-1:0] wr_addr, rd_req_addr;
  logic [DW-1:0] wr_data, rd_data = '0;
  logic busy, done, rep_valid;
  logic [EW-1:0] rep_errors;
  logic [RW-1:0] reps_done;

  always #10 clk = ~clk;

  drt_seq #(.AW(AW), .DW(DW), .ERR_W(EW), .WAIT_W(WW), .REP_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base), .cfg_last(cfg_last),
    .cfg_wait(cfg_wait), .cfg_reps(cfg_reps), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_data_valid(rd_data_valid),
    .rd_data_ready(rd_data_ready), .rd_data(rd_data), .busy(busy), .done(done),
    .rep_valid(rep_valid), .rep_errors(rep_errors), .reps_done(reps_done));

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] sa0 [16];
  logic [DW-1:0] sa1 [16];
  int wr_a [256]; int wr_p [256]; int wr_n;
  int rd_a [256]; int rd_n;
  int gap_v [64]; int gap_n; int gap; bit gap_arm;
  int rep_log [16]; int rep_n; int done_n; bit done_busy_bad;
  bit pend; int pcnt; int paddr; bit spur_en; int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (done) begin done_n++; if (busy) done_busy_bad = 1; end
      if (rep_valid && rep_n < 16) begin rep_log[rep_n] = int'(rep_errors); rep_n++; end
      if (gap_arm && rd_req_valid) begin
        if (gap_n < 64) gap_v[gap_n] = gap;
        gap_n++; gap_arm = 0;
      end else gap++;
      wr_ready = (cyc % 3) != 1;
      if (wr_valid && wr_ready) begin
        if (wr_n < 256) begin
          wr_a[wr_n] = int'(wr_addr);
          wr_p[wr_n] = (wr_data == '0) ? 0 : (wr_data == '1) ? 1 : 2;
        end
        wr_n++;
        mem[wr_addr] = wr_data;
        gap = 0; gap_arm = 1;
      end
      rd_data_valid = 1'b0;
      if (pend) begin
        if (pcnt == 0) begin
          rd_data_valid = 1'b1;
          rd_data = (mem[paddr] & ~sa0[paddr]) | sa1[paddr];
          pend = 0;
        end else pcnt--;
      end else if (spur_en && !rd_data_ready && (cyc % 5) == 0) begin
        rd_data_valid = 1'b1;
        rd_data = {8{$urandom}};
      end
      rd_req_ready = (cyc % 2) == 0;
      if (rd_req_valid && rd_req_ready) begin
        if (rd_n < 256) rd_a[rd_n] = int'(rd_req_addr);
        rd_n++;
        pend = 1; pcnt = cyc % 3; paddr = int'(rd_req_addr);
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int expected_rep(input int b, input int l);
    int s = 0;
    for (int a = b; a <= l; a++) s += 2 * ($countones(sa0[a]) + $countones(sa1[a]));
    return (s > SATV) ? SATV : s;
  endfunction

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; gap_n = 0; gap_arm = 0; rep_n = 0; done_n = 0; done_busy_bad = 0;
  endtask

  task automatic pulse_start(input int b, input int l, input int w, input int r);
    cfg_base = AW'(b); cfg_last = AW'(l); cfg_wait = WW'(w); cfg_reps = RW'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done_n == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_run(input int b, input int l, input int w, input int r, input string tag);
    int reps = (r == 0) ? 1 : r;
    int n = l - b + 1;
    int k = 0, bad_w = 0, bad_r = 0, bad_g = 0, bad_rep = 0;
    int ew = (w == 0) ? 1 : w;
    int exp_rep = expected_rep(b, l);
    for (int rp = 0; rp < reps; rp++)
      for (int p = 0; p < 4; p++)
        for (int i = 0; i < n; i++) begin
          int a = p[1] ? (l - i) : (b + i);
          if (k < 256) begin
            if (wr_a[k] != a || wr_p[k] != p[0]) bad_w++;
            if (rd_a[k] != a) bad_r++;
          end
          k++;
        end
    chk(wr_n == k && bad_w == 0, {tag, " R3 R4 write order/pattern"}, bad_w + wr_n, k);
    chk(rd_n == k && bad_r == 0, {tag, " R1 R5 read order"}, bad_r + rd_n, k);
    for (int g = 0; g < gap_n && g < 64; g++) if (gap_v[g] != ew) bad_g++;
    chk(gap_n == 4 * reps && bad_g == 0, {tag, " R2 idle length"}, (gap_n > 0) ? gap_v[0] : -1, ew);
    for (int i = 0; i < rep_n && i < 16; i++) if (rep_log[i] != exp_rep) bad_rep++;
    chk(bad_rep == 0, {tag, " R6 R7 repetition result"}, (rep_n > 0) ? rep_log[0] : -1, exp_rep);
    chk(rep_n == reps && int'(reps_done) == reps, {tag, " R8 repetition count"}, rep_n, reps);
    chk(done_n == 1 && !done_busy_bad && !busy, {tag, " R9 done pulse"}, done_n, 1);
  endtask

  task automatic run(input int b, input int l, input int w, input int r, input string tag);
    clear_logs();
    pulse_start(b, l, w, r);
    chk(busy == 1'b1, {tag, " R9 busy after start"}, int'(busy), 1);
    wait_done();
    check_run(b, l, w, r, tag);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) begin mem[a] = '0; sa0[a] = '0; sa1[a] = '0; end
    pend = 0; spur_en = 0; clear_logs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !wr_valid && !rd_req_valid && !rd_data_ready && !rep_valid
        && rep_errors == 0 && reps_done == 0, "R11 reset state", int'(busy), 0);

    run(0, 3, 5, 1, "clean");

    sa1[1] = 256'h7;
    sa0[2] = 256'h1F << 100;
    run(0, 3, 3, 2, "sparse");

    sa1[4] = 256'h7F;
    sa1[9] = 256'h1 << 255;
    sa0[5] = 256'h3 << 40;
    spur_en = 1;
    run(5, 9, 2, 1, "window+spurious R5");

    run(7, 7, 0, 0, "single R2 R8");

    // R10: second start while busy is ignored
    clear_logs();
    pulse_start(0, 3, 20, 1);
    repeat (4) @(negedge clk);
    pulse_start(0, 15, 1, 3);
    wait_done();
    check_run(0, 3, 20, 1, "R10 restart ignored");
    repeat (5) @(negedge clk);
    chk(!busy && done_n == 1, "R10 no second run", done_n, 1);

    // R7 saturation
    spur_en = 0;
    for (int a = 0; a < 16; a++) begin sa0[a] = '0; sa1[a] = '1; end
    run(0, 15, 2, 1, "R7 saturate");
    chk(int'(rep_errors) == SATV, "R7 saturated value", int'(rep_errors), SATV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule